// File: doc/BRIEF.md
# Inter-Core Interrupt Mailbox Controller

This block lets any of several processor cores raise an interrupt on any other core and attach a set of source flags that tell the receiver who is calling. It has one doorbell register and one acknowledge register for each target core, on a simple single-cycle register bus. It drives one interrupt line per target. The doorbell and the acknowledge register for a target are two views of the same 28-bit flag set. A sender sets flags and rings the doorbell. The receiver reads the flags and clears the ones it has handled through the acknowledge view, which clears them in both views.

A two-key guard protects the doorbell registers. Doorbell writes take effect only after both key registers hold their unlock values. Writing any other value to either key register locks the guard again. Acknowledge writes are never guarded, so a receiver can always retire its flags.

Register map, one 32-bit register per word address: doorbell x at address x (0 to 7), acknowledge x at address 8+x, key A at address 16, key B at address 17. Reads are combinational from the current address.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every doorbell and acknowledge register reads 0, every interrupt line is low, and the guard is locked.
- R2: A doorbell write to address x with bit 0 set, while unlocked, drives irq_o[x] high for exactly the one clock cycle after the write edge.
- R3: A doorbell write while unlocked sets the target's flags from write-data bits 31:4 (write-1-to-set). Zero bits leave their flags unchanged.
- R4: The acknowledge register 8+x reads the same flag set in bits 31:4 as doorbell register x.
- R5: A write to acknowledge address 8+x clears every target-x flag whose write-data bit in 31:4 is 1, in both views. Zero bits have no effect.
- R6: Bits 3:0 of every read are 0, doorbell bit 0 reads back as 0, and key registers and unmapped addresses read 0.
- R7: A doorbell write while locked changes no flag and raises no interrupt.
- R8: The guard unlocks only once key A (address 16) holds 32'h1F2E3D4C and key B (address 17) holds 32'hA5B6C7D8. The two keys may be written in either order, and one key alone does not unlock.
- R9: Writing any other value to key A or key B locks the guard again.
- R10: Acknowledge writes take effect whether the guard is locked or not.
- R11: A write that addresses target x changes only target x's flags and interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 8 | One interrupt pulse line per target core |

## Verification
The assertions assume the bus makes at most one write per cycle and that bus_addr and bus_wdata are stable and known while bus_we is high. They also assume the bus is idle during reset. The bench drives every input on the falling edge, holds bus_we for one cycle per transfer, and keeps it low throughout reset. Doorbells are never written back to back, so every interrupt line is high for at most one cycle and can be checked as a single pulse.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DATA_W = 32;
  localparam int RSV_W  = 4;
  localparam int SRC_W  = DATA_W - RSV_W;
  localparam logic [DATA_W-1:0] KEY_A = 32'h1F2E_3D4C;
  localparam logic [DATA_W-1:0] KEY_B = 32'hA5B6_C7D8;

  function automatic logic [SRC_W-1:0] src_field(input logic [DATA_W-1:0] w);
    return w[DATA_W-1:RSV_W];
  endfunction

  function automatic logic [SRC_W-1:0] flags_set(input logic [SRC_W-1:0] old_f,
                                                 input logic [SRC_W-1:0] mask);
    return old_f | mask;
  endfunction

  function automatic logic [SRC_W-1:0] flags_clr(input logic [SRC_W-1:0] old_f,
                                                 input logic [SRC_W-1:0] mask);
    return old_f & ~mask;
  endfunction

  function automatic logic [DATA_W-1:0] reg_view(input logic [SRC_W-1:0] f);
    return {f, {RSV_W{1'b0}}};
  endfunction
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
  parameter int NUM_CORES = 8,
  parameter int ADDR_W    = 5
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_CORES-1:0] gen_hit,
  output logic [NUM_CORES-1:0] ack_hit,
  output logic                 key_a_hit,
  output logic                 key_b_hit
);
  localparam logic [ADDR_W-1:0] KEY_A_ADDR = ADDR_W'(2 * NUM_CORES);
  localparam logic [ADDR_W-1:0] KEY_B_ADDR = ADDR_W'(2 * NUM_CORES + 1);

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] GEN_ADDR = ADDR_W'(i);
    localparam logic [ADDR_W-1:0] ACK_ADDR = ADDR_W'(NUM_CORES + i);
    assign gen_hit[i] = (addr == GEN_ADDR);
    assign ack_hit[i] = (addr == ACK_ADDR);
  end

  assign key_a_hit = (addr == KEY_A_ADDR);
  assign key_b_hit = (addr == KEY_B_ADDR);
endmodule

// File: rtl/mbx_keylock.sv
module mbx_keylock
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_key_a,
  input  logic              wr_key_b,
  input  logic [DATA_W-1:0] wdata,
  output logic              unlocked
);
  logic a_ok_q, b_ok_q;
  logic bad_write;

  // any wrong value written to either key drops both halves of the guard
  assign bad_write = (wr_key_a && (wdata != KEY_A)) || (wr_key_b && (wdata != KEY_B));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_ok_q <= 1'b0;
      b_ok_q <= 1'b0;
    end else if (bad_write) begin
      a_ok_q <= 1'b0;
      b_ok_q <= 1'b0;
    end else begin
      if (wr_key_a) a_ok_q <= 1'b1;
      if (wr_key_b) b_ok_q <= 1'b1;
    end
  end

  assign unlocked = a_ok_q && b_ok_q;
endmodule

// File: rtl/mbx_target.sv
module mbx_target
  import mbx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic             ring,
  input  logic [SRC_W-1:0] mask,
  output logic [SRC_W-1:0] flags,
  output logic             irq
);
  logic [SRC_W-1:0] flags_q;
  logic             irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (set_en)      flags_q <= flags_set(flags_q, mask);
      else if (clr_en) flags_q <= flags_clr(flags_q, mask);
      irq_q <= set_en && ring;
    end
  end

  assign flags = flags_q;
  assign irq   = irq_q;
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbx_pkg::*;
#(
  parameter int  NUM_CORES = 8,
  localparam int ADDR_W    = $clog2(2 * NUM_CORES + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic                 bus_we,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [NUM_CORES-1:0] irq_o
);
  logic [NUM_CORES-1:0] gen_hit, ack_hit;
  logic                 key_a_hit, key_b_hit;
  logic                 unlocked;
  logic [NUM_CORES-1:0] gen_wr, ack_wr;
  logic [NUM_CORES-1:0][SRC_W-1:0] src_flat;
  logic [SRC_W-1:0]     wmask;

  mbx_decode #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_decode (
    .addr      (bus_addr),
    .gen_hit   (gen_hit),
    .ack_hit   (ack_hit),
    .key_a_hit (key_a_hit),
    .key_b_hit (key_b_hit)
  );

  mbx_keylock u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_key_a (bus_we && key_a_hit),
    .wr_key_b (bus_we && key_b_hit),
    .wdata    (bus_wdata),
    .unlocked (unlocked)
  );

  // named write events, brought out for the checker
  assign gen_wr = gen_hit & {NUM_CORES{bus_we && unlocked}};
  assign ack_wr = ack_hit & {NUM_CORES{bus_we}};
  assign wmask  = src_field(bus_wdata);

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_tgt
    mbx_target u_tgt (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (gen_wr[i]),
      .clr_en (ack_wr[i]),
      .ring   (bus_wdata[0]),
      .mask   (wmask),
      .flags  (src_flat[i]),
      .irq    (irq_o[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (gen_hit[i] || ack_hit[i]) bus_rdata = reg_view(src_flat[i]);
    end
  end
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk
  import mbx_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int ADDR_W    = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic                 bus_we,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic [NUM_CORES-1:0] irq_o,
  input logic                 unlocked,
  input logic [NUM_CORES-1:0][SRC_W-1:0] src_flat
);
  localparam logic [ADDR_W-1:0] KA = ADDR_W'(2 * NUM_CORES);
  localparam logic [ADDR_W-1:0] KB = ADDR_W'(2 * NUM_CORES + 1);

  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[RSV_W-1:0] == '0);

  p_one_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_o));

  p_unlock_by_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(bus_we && (bus_addr == KA || bus_addr == KB)));

  p_relock_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == KA && bus_wdata != KEY_A) |=> !unlocked);

  p_relock_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == KB && bus_wdata != KEY_B) |=> !unlocked);

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_chk
    localparam logic [ADDR_W-1:0] GA = ADDR_W'(i);
    localparam logic [ADDR_W-1:0] AA = ADDR_W'(NUM_CORES + i);

    p_pulse_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[i] |-> $past(bus_we && bus_addr == GA && bus_wdata[0] && unlocked));

    p_set_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == GA && unlocked) |=>
        ((src_flat[i] & $past(src_field(bus_wdata))) == $past(src_field(bus_wdata))));

    p_locked_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == GA && !unlocked) |=> ($stable(src_flat[i]) && !irq_o[i]));

    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == AA) |=> ((src_flat[i] & $past(src_field(bus_wdata))) == '0));
  end
endmodule

bind ipc_mailbox ipc_mailbox_chk #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .unlocked  (unlocked),
  .src_flat  (src_flat)
);

// File: tb/test_ipc_mailbox.sv
`timescale 1ns/1ps
module test_ipc_mailbox;
  localparam int N = 8;
  localparam logic [31:0] KA_VAL = 32'h1F2E_3D4C;
  localparam logic [31:0] KB_VAL = 32'hA5B6_C7D8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [27:0] model [N];

  always #2.5 clk = ~clk;

  ipc_mailbox i_ipc_mailbox (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // returns at the falling edge after the write edge: irq is visible now
  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic check_all_regs(input string req);
    logic [31:0] d;
    for (int t = 0; t < N; t++) begin
      bus_read(5'(t), d);
      check(req, d, {model[t], 4'h0});
      bus_read(5'(N + t), d);
      check(req, d, {model[t], 4'h0});
    end
    @(negedge clk);
  endtask

  function automatic logic [31:0] pattern(input int t, input int k);
    logic [31:0] v = (32'(t) + 1) * 32'h0913_5A7B + 32'(k) * 32'h2468_ACE1;
    return {v[7:0], v[31:8]};
  endfunction

  initial begin
    logic [31:0] d;
    for (int t = 0; t < N; t++) model[t] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, guard locked
    check("R1 irq", {24'h0, irq_o}, 32'h0);
    check_all_regs("R1");

    // R7: locked doorbell write ignored
    bus_write(5'd3, 32'hFFFF_FFF1);
    check("R7 irq", {24'h0, irq_o}, 32'h0);
    check_all_regs("R7");

    // R8: key A alone does not unlock
    bus_write(5'd16, KA_VAL);
    bus_write(5'd2, 32'h0000_0031);
    check("R8 one key irq", {24'h0, irq_o}, 32'h0);
    check_all_regs("R8 one key");

    // R8: second key unlocks
    bus_write(5'd17, KB_VAL);

    // R2 R3 R11: sweep all targets with bit 0 set
    for (int t = 0; t < N; t++) begin
      d = pattern(t, 0);
      bus_write(5'(t), d | 32'h1);
      check("R2 R11 pulse", {24'h0, irq_o}, 32'h1 << t);
      @(negedge clk);
      check("R2 one cycle", {24'h0, irq_o}, 32'h0);
      model[t] = model[t] | d[31:4];
      check_all_regs("R3 R4 R11");
    end

    // R3: write-1-to-set with bit 0 clear, no pulse
    for (int t = 0; t < N; t++) begin
      d = pattern(t, 1) & 32'hFFFF_FFF0;
      bus_write(5'(t), d);
      check("R3 no ring", {24'h0, irq_o}, 32'h0);
      model[t] = model[t] | d[31:4];
    end
    check_all_regs("R3 W1S");

    // R6: reserved write bits do nothing; key and unmapped reads are 0
    bus_write(5'd5, 32'h0000_000E);
    check("R6 irq", {24'h0, irq_o}, 32'h0);
    check_all_regs("R6");
    for (int a = 2 * N; a < 32; a++) begin
      bus_read(5'(a), d);
      check("R6 unmapped", d, 32'h0);
    end
    @(negedge clk);

    // R5: ack write-1-to-clear; zero write has no effect
    bus_write(5'(N + 4), 32'h0);
    check_all_regs("R5 zero");
    for (int t = 0; t < N; t++) begin
      d = pattern(t, 2);
      bus_write(5'(N + t), d);
      check("R5 irq", {24'h0, irq_o}, 32'h0);
      model[t] = model[t] & ~d[31:4];
    end
    check_all_regs("R5 W1C");

    // R9: bad key value relocks
    bus_write(5'd16, 32'h0);
    bus_write(5'd1, 32'hF000_0001);
    check("R9 irq", {24'h0, irq_o}, 32'h0);
    check_all_regs("R9");

    // R10: ack works while locked
    bus_write(5'(N + 0), 32'hFFFF_FFF0);
    model[0] = '0;
    check_all_regs("R10");

    // R9 on key B, then R8 order B before A
    bus_write(5'd16, KA_VAL);
    bus_write(5'd17, KB_VAL);
    bus_write(5'd17, 32'h1234_5678);
    bus_write(5'd6, 32'h0F00_0001);
    check("R9 key B irq", {24'h0, irq_o}, 32'h0);
    check_all_regs("R9 key B");
    bus_write(5'd17, KB_VAL);
    bus_write(5'd16, KA_VAL);
    bus_write(5'd7, 32'h8000_0011);
    check("R8 B then A irq", {24'h0, irq_o}, 32'h80);
    model[7] = model[7] | 28'h800_0001;
    check_all_regs("R8 B then A");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule